// File: doc/BRIEF.md
# DSP Bus Glue and I/O Expander

This block sits beside a signal processor on its external I/O bus. It turns a small set of address lines, qualified by the processor's active-low I/O-space strobe, into select lines for the flash device, the LCD controller and its own registers. Address bits 2:0 and 14:8 take no part in decoding, so each peripheral can use the low three bits for its own internal registers. It also makes separate flash read and write strobes from the select and the read/write line.

Inside, the block adds a byte of general-purpose I/O: an 8-bit output latch that the processor writes (its low bits carry the flash program-page select), and an 8-bit input port that the processor reads through the low byte of the data bus, with a pad enable that is raised only for that read. A routing register lets software connect any of eight active-low external interrupt lines to each of the processor's four active-low interrupt inputs. The external lines are resynchronised to the block clock before routing.

Register writes are handled by a two-state bus tracker. ST_IDLE waits for an access. The *access start* transition from ST_IDLE to ST_HOLD is taken on the first clock edge where any select is active, and a write to the latch or to the routing register is captured on that edge only. ST_HOLD waits for the access to end. The *access end* transition from ST_HOLD back to ST_IDLE is taken when no select is active any more.

Top module: `busglue_top`

## Requirements
- R1: A select is active only while io_strobe_n is 0 and addr[15] is 1. The region field addr[7:3] then picks the target: 0 is flash (cs_flash_n low), 1 is LCD (cs_lcd_n low), 2 is the output latch, 3 is the input port and 4 is the routing register. Bits 2:0 and 14:8 have no effect on the decoding.
- R2: flash_rd_n is low exactly when flash is selected and rw is 1 (read). flash_wr_n is low exactly when flash is selected and rw is 0 (write).
- R3: A write to region 2 (rw = 0) captures dbus_i[7:0] into out_port on the first clock edge of the access. The value is visible after that edge.
- R4: While an access is still held after its first edge, changes on dbus_i do not alter out_port or the routing.
- R5: A read of region 3 (rw = 1) raises dbus_oe and presents in_port on dbus_o.
- R6: dbus_oe is 0 whenever no read of region 3 is in progress.
- R7: A write to region 4 loads dbus_i[11:0] as four 3-bit selectors on the first clock edge of the access. The selector for interrupt output k sits in bits 3k+2:3k.
- R8: dsp_int_n[k] equals ext_irq_n[selector k] as it was two clock edges earlier. The path adds two edges of delay.
- R9: After reset, out_port is 0 and the selectors are 0, 1, 2, 3, so dsp_int_n[k] follows ext_irq_n[k].
- R10: Accesses with addr[15] = 0, with io_strobe_n high, or to regions 5 through 31 change no register and assert no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus is synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor address bus |
| io_strobe_n | input | 1 | Active-low I/O-space strobe |
| rw | input | 1 | 1 for read, 0 for write |
| dbus_i | input | 16 | Data bus as seen at the pad input |
| dbus_o | output | 8 | Low-byte read data toward the pad |
| dbus_oe | output | 1 | Pad output enable for the low byte |
| in_port | input | 8 | Status input port |
| out_port | output | 8 | Latched output port; low bits drive the flash page |
| ext_irq_n | input | 8 | Active-low external interrupt sources |
| dsp_int_n | output | 4 | Active-low interrupt inputs of the processor |
| cs_flash_n | output | 1 | Flash select |
| cs_lcd_n | output | 1 | LCD select |
| flash_rd_n | output | 1 | Flash read strobe |
| flash_wr_n | output | 1 | Flash write strobe |

## Verification
The assertions assume that the bus is synchronous to clk, and that each access holds its address, strobe and rw level steady until io_strobe_n returns high for at least one clock. This is what lets the bus tracker capture exactly one write per access. The stimulus drives every access on a falling edge, keeps it for two rising edges, and changes the write data between those edges to exercise the hold rule. It then releases the strobe for a full cycle before the next access. The random address bits outside the decoded field, the interrupt lines and the input port are changed freely, because the assertions place no constraint on them.

// File: rtl/busglue_pkg.sv
package busglue_pkg;

    // width of the decoded region field and its position on the address bus
    localparam int unsigned REGION_W  = 5;
    localparam int unsigned REGION_LO = 3;

    localparam logic [REGION_W-1:0] RG_FLASH  = 5'd0;
    localparam logic [REGION_W-1:0] RG_LCD    = 5'd1;
    localparam logic [REGION_W-1:0] RG_OUTLAT = 5'd2;
    localparam logic [REGION_W-1:0] RG_INPORT = 5'd3;
    localparam logic [REGION_W-1:0] RG_ROUTE  = 5'd4;

    typedef struct packed {
        logic flash;
        logic lcd;
        logic outlat;
        logic inport;
        logic route;
    } sel_t;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } bus_state_e;

endpackage

// File: rtl/busglue_decode.sv
module busglue_decode
    import busglue_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned SPACE_B = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_strobe_n,
    output sel_t              sel
);
    localparam int unsigned REGION_HI = REGION_LO + REGION_W - 1;

    logic                hit;
    logic [REGION_W-1:0] region;

    assign hit    = ~io_strobe_n & addr[SPACE_B];
    assign region = addr[REGION_HI:REGION_LO];

    always_comb begin
        sel        = '0;
        sel.flash  = hit && (region == RG_FLASH);
        sel.lcd    = hit && (region == RG_LCD);
        sel.outlat = hit && (region == RG_OUTLAT);
        sel.inport = hit && (region == RG_INPORT);
        sel.route  = hit && (region == RG_ROUTE);
    end

    // bits left to the peripherals themselves
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[SPACE_B-1:REGION_HI+1], addr[REGION_LO-1:0]};

endmodule

// File: rtl/busglue_fsm.sv
module busglue_fsm
    import busglue_pkg::*;
#(
    parameter int unsigned OUT_W   = 8,
    parameter int unsigned ROUTE_W = 12,
    parameter logic [ROUTE_W-1:0] ROUTE_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sel_t               sel,
    input  logic               rw,
    input  logic [ROUTE_W-1:0] wdata,
    output logic [OUT_W-1:0]   out_q,
    output logic [ROUTE_W-1:0] route_q
);
    bus_state_e state_q, state_d;
    logic       any_sel;
    logic       latch_we;
    logic       route_we;

    assign any_sel = |sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and write enables
    always_comb begin
        state_d  = state_q;
        latch_we = 1'b0;
        route_we = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_sel) begin
                    state_d  = ST_HOLD;
                    latch_we = sel.outlat & ~rw;
                    route_we = sel.route  & ~rw;
                end
            end
            ST_HOLD: begin
                if (!any_sel) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            route_q <= ROUTE_RST;
        end else begin
            if (latch_we) out_q   <= wdata[OUT_W-1:0];
            if (route_we) route_q <= wdata;
        end
    end

    // R3: first edge of a latch write captures the bus
    a_r3_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sel.outlat && !rw) |=> (out_q == $past(wdata[OUT_W-1:0])));

    // R7: first edge of a routing write captures the bus
    a_r7_route_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sel.route && !rw) |=> (route_q == $past(wdata)));

    // R4: nothing is written while an access is held
    a_r4_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> ($stable(out_q) && $stable(route_q)));

    // R10: with no select the registers keep their value
    a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_sel) |=> ($stable(out_q) && $stable(route_q) && state_q == ST_IDLE));

endmodule

// File: rtl/busglue_irq_xbar.sv
module busglue_irq_xbar #(
    parameter int unsigned NSRC  = 8,
    parameter int unsigned NDST  = 4,
    parameter int unsigned SEL_W = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_n,
    input  logic [NDST*SEL_W-1:0] route,
    output logic [NDST-1:0]       dst_n
);
    logic [NSRC-1:0] sync1_q;
    logic [NSRC-1:0] sync2_q;

    // two-stage resynchroniser, idle level high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
        end else begin
            sync1_q <= src_n;
            sync2_q <= sync1_q;
        end
    end

    for (genvar k = 0; k < NDST; k++) begin : g_dst
        logic [SEL_W-1:0] pick;
        assign pick     = route[k*SEL_W +: SEL_W];
        assign dst_n[k] = sync2_q[pick];

        // R8: the output is the selected source from the first stage, one edge later
        a_r8_route_delay: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(pick) |-> (dst_n[k] == $past(sync1_q[pick])));
    end

endmodule

// File: rtl/busglue_top.sv
module busglue_top
    import busglue_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DW     = 16,
    parameter int unsigned OUT_W  = 8,
    parameter int unsigned IN_W   = 8,
    parameter int unsigned NSRC   = 8,
    parameter int unsigned NDST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_strobe_n,
    input  logic              rw,
    input  logic [DW-1:0]     dbus_i,
    output logic [IN_W-1:0]   dbus_o,
    output logic              dbus_oe,
    input  logic [IN_W-1:0]   in_port,
    output logic [OUT_W-1:0]  out_port,
    input  logic [NSRC-1:0]   ext_irq_n,
    output logic [NDST-1:0]   dsp_int_n,
    output logic              cs_flash_n,
    output logic              cs_lcd_n,
    output logic              flash_rd_n,
    output logic              flash_wr_n
);
    localparam int unsigned SEL_W   = $clog2(NSRC);
    localparam int unsigned ROUTE_W = NDST * SEL_W;

    function automatic logic [ROUTE_W-1:0] route_default();
        logic [ROUTE_W-1:0] r;
        r = '0;
        for (int k = 0; k < NDST; k++) r[k*SEL_W +: SEL_W] = SEL_W'(k);
        return r;
    endfunction

    localparam logic [ROUTE_W-1:0] ROUTE_RST = route_default();

    sel_t               sel;
    logic [ROUTE_W-1:0] route_q;

    busglue_decode #(
        .ADDR_W (ADDR_W),
        .SPACE_B(ADDR_W - 1)
    ) u_decode (
        .addr       (addr),
        .io_strobe_n(io_strobe_n),
        .sel        (sel)
    );

    busglue_fsm #(
        .OUT_W    (OUT_W),
        .ROUTE_W  (ROUTE_W),
        .ROUTE_RST(ROUTE_RST)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .rw     (rw),
        .wdata  (dbus_i[ROUTE_W-1:0]),
        .out_q  (out_port),
        .route_q(route_q)
    );

    busglue_irq_xbar #(
        .NSRC (NSRC),
        .NDST (NDST),
        .SEL_W(SEL_W)
    ) u_xbar (
        .clk  (clk),
        .rst_n(rst_n),
        .src_n(ext_irq_n),
        .route(route_q),
        .dst_n(dsp_int_n)
    );

    logic unused_dbus_hi;
    assign unused_dbus_hi = ^dbus_i[DW-1:ROUTE_W];

    assign cs_flash_n = ~sel.flash;
    assign cs_lcd_n   = ~sel.lcd;
    assign flash_rd_n = ~(sel.flash &  rw);
    assign flash_wr_n = ~(sel.flash & ~rw);
    assign dbus_oe    = sel.inport & rw;
    assign dbus_o     = dbus_oe ? in_port : '0;

    // R1: at most one of the port-level selects and the read enable at a time
    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~cs_flash_n, ~cs_lcd_n, dbus_oe}));

    // R6: the pad is driven only during a strobed read
    a_r6_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (rw && !io_strobe_n && addr[ADDR_W-1]));

    // R2: flash strobes never both active and only with the select
    a_r2_strobe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_rd_n || !flash_wr_n) |-> (!cs_flash_n && (flash_rd_n != flash_wr_n)));

endmodule

// File: tb/busglue_top_test.sv
`timescale 1ns/1ps
module busglue_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        io_strobe_n = 1'b1;
    logic        rw = 1'b1;
    logic [15:0] dbus_i = '0;
    logic [7:0]  dbus_o;
    logic        dbus_oe;
    logic [7:0]  in_port = '0;
    logic [7:0]  out_port;
    logic [7:0]  ext_irq_n = '1;
    logic [3:0]  dsp_int_n;
    logic        cs_flash_n, cs_lcd_n, flash_rd_n, flash_wr_n;

    int checks = 0;
    int errors = 0;

    logic [7:0]  exp_out;
    logic [11:0] exp_route;
    logic [7:0]  e1, e2;

    always #2.5 clk = ~clk;

    busglue_top uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_strobe_n(io_strobe_n), .rw(rw),
        .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe(dbus_oe), .in_port(in_port),
        .out_port(out_port), .ext_irq_n(ext_irq_n), .dsp_int_n(dsp_int_n),
        .cs_flash_n(cs_flash_n), .cs_lcd_n(cs_lcd_n),
        .flash_rd_n(flash_rd_n), .flash_wr_n(flash_wr_n)
    );

    // two-edge delay model of the interrupt path
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e1 <= '1;
            e2 <= '1;
        end else begin
            e1 <= ext_irq_n;
            e2 <= e1;
        end
    end

    function automatic bit f_hit(input logic [15:0] a, input logic s_n, input int rg);
        return !s_n && a[15] && (a[7:3] == rg[4:0]);
    endfunction

    function automatic logic [3:0] f_int(input logic [7:0] src, input logic [11:0] rt);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = src[rt[k*3 +: 3]];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_ports();
        bit hf, hl, hi;
        hf = f_hit(addr, io_strobe_n, 0);
        hl = f_hit(addr, io_strobe_n, 1);
        hi = f_hit(addr, io_strobe_n, 3);
        chk("R1 cs_flash_n", cs_flash_n, !hf);
        chk("R1 cs_lcd_n", cs_lcd_n, !hl);
        chk("R2 flash_rd_n", flash_rd_n, !(hf && rw));
        chk("R2 flash_wr_n", flash_wr_n, !(hf && !rw));
        chk("R5 R6 dbus_oe", dbus_oe, hi && rw);
        if (hi && rw) chk("R5 dbus_o", dbus_o, in_port);
        chk("R3 R4 R10 out_port", out_port, exp_out);
        chk("R7 R8 dsp_int_n", dsp_int_n, f_int(e2, exp_route));
    endtask

    // one access: drive at a falling edge, hold for two rising edges, release
    task automatic access(input logic [15:0] a, input logic r, input logic [15:0] d, input logic s_n);
        addr = a; rw = r; dbus_i = d; io_strobe_n = s_n;
        #1 check_ports();
        @(posedge clk);
        if (!s_n && a[15] && !r && a[7:3] == 5'd2) exp_out = d[7:0];
        if (!s_n && a[15] && !r && a[7:3] == 5'd4) exp_route = d[11:0];
        @(negedge clk);
        dbus_i = 16'($urandom);     // R4: late data change must be ignored
        #1 check_ports();
        @(negedge clk);
        io_strobe_n = 1'b1;
        #1 check_ports();
        @(negedge clk);
    endtask

    function automatic logic [15:0] mk_addr(input int rg);
        logic [15:0] a;
        a = 16'($urandom);
        a[15] = 1'b1;
        a[7:3] = rg[4:0];
        return a;
    endfunction

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        exp_out = '0;
        exp_route = {3'd3, 3'd2, 3'd1, 3'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset values
        chk("R9 out_port reset", out_port, 8'h00);
        ext_irq_n = 8'b1111_0101;
        repeat (3) @(negedge clk);
        chk("R9 identity routing", dsp_int_n, 4'b0101);

        // R8: exactly two edges of delay
        ext_irq_n = 8'b1111_0100;
        @(negedge clk);
        chk("R8 after one edge", dsp_int_n[0], 1'b1);
        @(negedge clk);
        chk("R8 after two edges", dsp_int_n[0], 1'b0);

        // R3 and R1: latch write with junk in ignored address bits
        access(16'b1111_1111_0001_0111, 1'b0, 16'h00A5, 1'b0);
        chk("R3 directed latch", out_port, 8'hA5);

        // R7: route every output to source 7
        ext_irq_n = 8'h7F;
        access(mk_addr(4), 1'b0, {4'h0, 3'd7, 3'd7, 3'd7, 3'd7}, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7 all to source 7", dsp_int_n, 4'b0000);

        // R10: out-of-space, unstrobed and unused-region writes
        access({1'b0, mk_addr(2)[14:0]}, 1'b0, 16'h0033, 1'b0);
        chk("R10 A15 low", out_port, 8'hA5);
        access(mk_addr(2), 1'b0, 16'h0044, 1'b1);
        chk("R10 no strobe", out_port, 8'hA5);
        access(mk_addr(9), 1'b0, 16'h0055, 1'b0);
        chk("R10 unused region", out_port, 8'hA5);

        // R5: input port read
        in_port = 8'h3C;
        access(mk_addr(3), 1'b1, 16'h0000, 1'b0);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            int rg;
            logic [15:0] a;
            op = int'($urandom_range(0, 6));
            if ($urandom_range(0, 3) == 0) ext_irq_n = 8'($urandom);
            in_port = 8'($urandom);
            unique case (op)
                0: rg = 2;
                1: rg = 4;
                2: rg = 3;
                3: rg = 0;
                4: rg = 1;
                default: rg = int'($urandom_range(5, 31));
            endcase
            a = mk_addr(rg);
            if (op == 6) a[15] = 1'b0;
            access(a, 1'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule